// File: doc/BRIEF.md
# Self-Triggered Channel Hit Capture

This block is the digital half of one channel in a free-running, self-triggered detector readout. No external trigger exists. The discriminator output of the channel arrives asynchronously and passes through a synchronizer. Each rising edge of it latches the timestamp word present on the shared timestamp bus. The block converts that word to Gray code and stores it in a shallow FIFO, which absorbs the random arrival of hits until a readout token cell collects them.

Several controls decide whether a trigger is kept:
- A mask bit silences the discriminator.
- A shutdown control stops all capture and empties the FIFO.
- A forced-trigger input stores an entry without any discriminator activity, which is used for pedestal checks.
- A programmable dead time ignores triggers for a configured number of cycles after each accepted one.

A trigger that finds the FIFO full is lost and raises a one-cycle increment pulse for a shared overflow counter. Each stored entry raises a pulse-height-valid strobe. The readout cell sees the oldest entry and a not-empty flag, and pops one entry per acknowledge.

Top module: `hit_capture_channel`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_valid`, `ovf_inc` and `ph_strobe` are 0.
- R2: `disc_in` is resynchronized and edge-detected. When it rises before clock edge k, one entry is written at edge k+2, holding the Gray code (b XOR b>>1) of the `ts_bin` value sampled at that edge. `rd_valid` rises after edge k+2 and not before.
- R3: A `disc_in` level held high for many cycles produces exactly one entry.
- R4: While `cfg_mask` is 1, discriminator edges store nothing.
- R5: While `cfg_off` is 1, neither the discriminator nor `force_trig` stores anything. The FIFO is emptied at the first edge that samples `cfg_off` high, so `rd_valid` is 0 after that edge.
- R6: A `force_trig` high at an edge stores the Gray code of `ts_bin` at that same edge, even while `cfg_mask` is 1.
- R7: After a trigger is accepted at edge e, triggers at edges e+1 through e+`cfg_dead` are ignored, and a trigger at edge e+`cfg_dead`+1 is accepted. A `cfg_dead` of 0 blocks nothing.
- R8: The FIFO holds 4 entries and presents them oldest first on `rd_ts`. Each edge with `rd_ack` and `rd_valid` both high removes one entry.
- R9: An accepted trigger that meets a full FIFO with no pop in the same cycle is dropped, and the contents are unchanged. `ovf_inc` is 1 for exactly the cycle after that edge.
- R10: A trigger and a pop at the same edge on a full FIFO both take effect. The new entry is kept and `ovf_inc` stays 0.
- R11: `ph_strobe` is 1 for the cycle after each edge that stores an entry. It stays 0 after a dropped trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disc_in | input | 1 | Asynchronous discriminator output |
| ts_bin | input | TS_W | Binary timestamp word from the shared counter |
| cfg_mask | input | 1 | Mask discriminator hits |
| cfg_off | input | 1 | Channel shutdown; flushes and blocks capture |
| force_trig | input | 1 | Forced trigger, sampled each edge |
| cfg_dead | input | DEAD_W | Dead time in cycles after an accepted trigger |
| rd_ack | input | 1 | Readout cell acknowledge; pops the oldest entry |
| rd_valid | output | 1 | FIFO not empty |
| rd_ts | output | TS_W | Oldest entry, Gray-coded timestamp |
| ovf_inc | output | 1 | Increment pulse for the shared overflow counter |
| ph_strobe | output | 1 | Pulse-height-valid strobe for a stored hit |

## Verification
A discriminator edge reaches the FIFO after three register stages, counting from the edge that first samples the input. The bench therefore expects `rd_valid` three sampling points after it raises `disc_in`, and checks that it is still low one point earlier. A forced trigger, the overflow pulse and the strobe are each due one sampling point after the edge that acts on them. A pop shows its effect at the next sampling point. Inputs are driven and outputs sampled 1 ns after the falling edge, and the expected timestamp is taken from the bus value held for the edge the design should use.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
   // true when v is a nonzero power of two
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   localparam int HCC_MIN_SYNC = 2;
endpackage

// File: rtl/hcc_edge_sync.sv
module hcc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   if (STAGES < hcc_pkg::HCC_MIN_SYNC) begin : g_bad_stages
      $error("hcc_edge_sync: STAGES too small");
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R3
endmodule

// File: rtl/hcc_dead_timer.sv
module hcc_dead_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o
);
   if (CNT_W < 1) begin : g_bad_w
      $error("hcc_dead_timer: CNT_W must be positive");
   end

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)              remain <= '0;
      else if (start_i)        remain <= len_i;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign busy_o = (remain != '0);

   AST_DEAD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && len_i != '0) |=> busy_o); // R7
   AST_DEAD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !start_i); // R7
endmodule

// File: rtl/hcc_ts_fifo.sv
module hcc_ts_fifo #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              full_o,
   output logic              empty_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (!hcc_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("hcc_ts_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr;
   logic [AW:0]       count;
   logic              do_wr, do_rd;

   assign full_o  = (count == (AW+1)'(DEPTH));
   assign empty_o = (count == '0);
   assign do_rd   = rd_i & ~empty_o;
   assign do_wr   = wr_i & (~full_o | do_rd);
   assign rdata_o = mem[rptr];

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wdata_i;
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (AW+1)'(DEPTH)); // R8
   AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && rd_i && full_o && !flush_i) |=> full_o); // R10
endmodule

// File: rtl/hit_capture_channel.sv
module hit_capture_channel #(
   parameter int TS_W        = 12,
   parameter int FIFO_DEPTH  = 4,
   parameter int DEAD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disc_in,
   input  logic [TS_W-1:0]   ts_bin,
   input  logic              cfg_mask,
   input  logic              cfg_off,
   input  logic              force_trig,
   input  logic [DEAD_W-1:0] cfg_dead,
   input  logic              rd_ack,
   output logic              rd_valid,
   output logic [TS_W-1:0]   rd_ts,
   output logic              ovf_inc,
   output logic              ph_strobe
);
   if (TS_W < 2) begin : g_bad_ts
      $error("hit_capture_channel: TS_W must be at least 2");
   end

   logic            disc_rise;
   logic            dead_busy;
   logic            fifo_full, fifo_empty;
   logic            trig, take, pop, store, drop;
   logic [TS_W-1:0] ts_gray;

   hcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(disc_in), .rise_o(disc_rise)
   );

   assign ts_gray = ts_bin ^ (ts_bin >> 1);
   assign trig    = (disc_rise & ~cfg_mask) | force_trig;
   assign take    = trig & ~cfg_off & ~dead_busy;
   assign rd_valid = ~fifo_empty;
   assign pop     = rd_ack & rd_valid;
   assign store   = take & (~fifo_full | pop);
   assign drop    = take & ~store;

   hcc_dead_timer #(.CNT_W(DEAD_W)) u_dead (
      .clk(clk), .rst_n(rst_n), .start_i(take), .len_i(cfg_dead),
      .busy_o(dead_busy)
   );

   hcc_ts_fifo #(.DATA_W(TS_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush_i(cfg_off),
      .wr_i(store), .wdata_i(ts_gray), .rd_i(rd_ack),
      .rdata_o(rd_ts), .full_o(fifo_full), .empty_o(fifo_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_inc   <= 1'b0;
         ph_strobe <= 1'b0;
      end else begin
         ovf_inc   <= drop;
         ph_strobe <= store;
      end
   end

   AST_OFF_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_off |=> !rd_valid); // R5
   AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_inc |-> $past(fifo_full)); // R9
   AST_STROBE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ph_strobe |-> rd_valid); // R11
   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_inc && ph_strobe)); // R9
endmodule

// File: tb/hit_capture_channel_test.sv
`timescale 1ns/1ps
module hit_capture_channel_test;
   localparam int TS_W   = 12;
   localparam int DEAD_W = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              disc_in = 1'b0, cfg_mask = 1'b0, cfg_off = 1'b0;
   logic              force_trig = 1'b0, rd_ack = 1'b0;
   logic [DEAD_W-1:0] cfg_dead = '0;
   logic [TS_W-1:0]   ts_bin = '0;
   logic              rd_valid, ovf_inc, ph_strobe;
   logic [TS_W-1:0]   rd_ts;

   int checks = 0;
   int errors = 0;

   always @(negedge clk) ts_bin <= ts_bin + 1'b1;

   hit_capture_channel uut (
      .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .ts_bin(ts_bin),
      .cfg_mask(cfg_mask), .cfg_off(cfg_off), .force_trig(force_trig),
      .cfg_dead(cfg_dead), .rd_ack(rd_ack), .rd_valid(rd_valid),
      .rd_ts(rd_ts), .ovf_inc(ovf_inc), .ph_strobe(ph_strobe)
   );

   function automatic logic [TS_W-1:0] to_gray(input logic [TS_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pop_expect(input string req, input logic [TS_W-1:0] bin);
      chk({req, " valid"}, 32'(rd_valid), 32'd1);
      chk({req, " data"}, 32'(rd_ts), 32'(to_gray(bin)));
      rd_ack = 1'b1;
      tick();
      rd_ack = 1'b0;
   endtask

   task automatic t_reset;
      tick(3);
      chk("R1 valid in reset", 32'(rd_valid), 0);
      chk("R1 ovf in reset", 32'(ovf_inc), 0);
      chk("R1 strobe in reset", 32'(ph_strobe), 0);
      rst_n = 1'b1;
      tick();
      chk("R1 valid after reset", 32'(rd_valid), 0);
      chk("R1 strobe after reset", 32'(ph_strobe), 0);
   endtask

   task automatic t_disc_capture;
      logic [TS_W-1:0] t0;
      t0 = ts_bin;
      disc_in = 1'b1;
      tick(2);
      chk("R2 not yet valid", 32'(rd_valid), 0);
      tick();
      chk("R2 valid on time", 32'(rd_valid), 1);
      chk("R11 strobe on store", 32'(ph_strobe), 1);
      disc_in = 1'b0;
      tick();
      chk("R11 strobe single", 32'(ph_strobe), 0);
      pop_expect("R2", t0 + 2);
      chk("R8 empty after pop", 32'(rd_valid), 0);
   endtask

   task automatic t_level_once;
      logic [TS_W-1:0] t0;
      t0 = ts_bin;
      disc_in = 1'b1;
      tick(8);
      disc_in = 1'b0;
      tick(3);
      pop_expect("R3", t0 + 2);
      chk("R3 only one entry", 32'(rd_valid), 0);
   endtask

   task automatic t_mask_force;
      logic [TS_W-1:0] t0;
      cfg_mask = 1'b1;
      disc_in = 1'b1;
      tick(2);
      disc_in = 1'b0;
      tick(4);
      chk("R4 masked stores nothing", 32'(rd_valid), 0);
      t0 = ts_bin;
      force_trig = 1'b1;
      tick();
      force_trig = 1'b0;
      chk("R6 forced while masked", 32'(rd_valid), 1);
      pop_expect("R6", t0);
      cfg_mask = 1'b0;
   endtask

   task automatic t_dead;
      logic [TS_W-1:0] t0;
      cfg_dead = 8'd3;
      t0 = ts_bin;
      force_trig = 1'b1;
      tick(5);
      force_trig = 1'b0;
      tick(4);
      pop_expect("R7 first", t0);
      pop_expect("R7 after window", t0 + 4);
      chk("R7 window blocked", 32'(rd_valid), 0);
      cfg_dead = '0;
   endtask

   task automatic t_overflow;
      logic [TS_W-1:0] t0;
      t0 = ts_bin;
      force_trig = 1'b1;
      tick(4);
      chk("R9 no ovf while filling", 32'(ovf_inc), 0);
      tick();
      force_trig = 1'b0;
      chk("R9 ovf pulse", 32'(ovf_inc), 1);
      chk("R11 no strobe on drop", 32'(ph_strobe), 0);
      tick();
      chk("R9 ovf single cycle", 32'(ovf_inc), 0);
      for (int i = 0; i < 4; i++) pop_expect("R8 order", t0 + TS_W'(i));
      chk("R9 dropped entry absent", 32'(rd_valid), 0);
   endtask

   task automatic t_full_swap;
      logic [TS_W-1:0] t0, t4;
      t0 = ts_bin;
      force_trig = 1'b1;
      tick(4);
      t4 = ts_bin;
      rd_ack = 1'b1;
      tick();
      force_trig = 1'b0;
      rd_ack = 1'b0;
      chk("R10 no ovf on swap", 32'(ovf_inc), 0);
      chk("R10 strobe on swap", 32'(ph_strobe), 1);
      for (int i = 1; i < 4; i++) pop_expect("R10 kept", t0 + TS_W'(i));
      pop_expect("R10 new entry", t4);
      chk("R10 drained", 32'(rd_valid), 0);
   endtask

   task automatic t_off;
      force_trig = 1'b1;
      tick(2);
      force_trig = 1'b0;
      chk("R5 setup filled", 32'(rd_valid), 1);
      cfg_off = 1'b1;
      tick();
      chk("R5 flushed", 32'(rd_valid), 0);
      force_trig = 1'b1;
      tick();
      force_trig = 1'b0;
      chk("R5 force blocked", 32'(rd_valid), 0);
      disc_in = 1'b1;
      tick(2);
      disc_in = 1'b0;
      tick(3);
      chk("R5 disc blocked", 32'(rd_valid), 0);
      cfg_off = 1'b0;
      tick();
      chk("R5 stays empty", 32'(rd_valid), 0);
      chk("R5 no strobe", 32'(ph_strobe), 0);
   endtask

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_disc_capture();
      t_level_once();
      t_mask_force();
      t_dead();
      t_overflow();
      t_full_swap();
      t_off();
      tick(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule